// File: doc/BRIEF.md
# Oversampled 8N1 Serial Engine

This block is the bit-level half of a simple serial port. A free-running tick generator divides the system clock by a 16-bit divisor and produces a tick four times per bit period. The programmed divisor equals clock / (baud × 4) − 1. The transmitter takes one byte through a valid/ready handshake. It sends a low start bit, the eight data bits least significant first, and a high stop bit, holding each bit for four ticks.

The receiver passes the line through a two-flop synchronizer and takes a falling edge as a candidate start bit. At the second tick it checks that the line is still low. From then on it samples once every four ticks, which lands each sample near the middle of its bit. It delivers the byte together with a flag that marks a low stop bit.

FIFOs, registers and interrupts belong to a front end that sits around this block. The format is fixed at 8N1. There is no parity and no break.

Top module: `serial_8n1_engine`

## Requirements
- R1: After reset, `tx_ready` is 1, `txd` is 1 (idle line) and `rx_valid` is 0.
- R2: The tick repeats every `divisor`+1 clocks, and every transmitted bit lasts exactly 4 ticks. From the clock in which `txd` falls for the start bit to the clock in which `tx_ready` returns is exactly 40×(`divisor`+1) clocks.
- R3: A transmitted frame is one start bit of 0, then `tx_data` bit 0 through bit 7 in that order, then one stop bit of 1. The line stays 1 while idle.
- R4: A byte is accepted only in a cycle with `tx_valid` and `tx_ready` both high. `tx_ready` is low from the next cycle until the stop bit has completed, and `tx_data` is ignored while the frame is in progress.
- R5: A received frame (start 0, data least significant bit first, stop) is delivered as `rx_data` with a one-cycle `rx_valid` pulse.
- R6: `rx_frame_err` is 1 with the delivered byte when the stop-bit sample is 0, and 0 when it is 1. The byte is delivered in both cases.
- R7: A low pulse on `rxd` that has ended by the second tick after its falling edge is rejected: nothing is delivered. The next valid frame is still received.
- R8: Writing a new value to `divisor` restarts the tick counter, and the next frame runs entirely at the new rate.
- R9: Frames received back to back, each with a single stop bit and no idle gap, are all delivered correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| divisor | input | 16 | Tick divisor: clock/(baud*4) - 1 |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | Byte on `tx_data` is offered |
| tx_ready | output | 1 | Transmitter idle and able to accept |
| txd | output | 1 | Serial output line |
| rxd | input | 1 | Serial input line (asynchronous) |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle pulse: `rx_data` is new |
| rx_frame_err | output | 1 | Stop bit of the delivered byte was low |

## Verification
The bench builds the block with its default parameters: 16-bit divisor, 8 data bits, 4 ticks per bit and a two-stage synchronizer. At run time it programs divisors 0 to 3. Divisor 0 gives one tick every clock, where the four-clock bit exposes any off-by-one in the sample point. Divisor 3 leaves room to place a short glitch well inside a tick period. Switching between these small values exercises the counter restart and keeps each random frame short. That allows many random transmit and receive frames, with random stop-bit errors, within the run.

// File: rtl/ser8n1_pkg.sv
package ser8n1_pkg;
   typedef enum logic [1:0] {
      TXS_IDLE  = 2'd0,
      TXS_ARM   = 2'd1,
      TXS_SHIFT = 2'd2
   } txs_t;

   typedef enum logic [1:0] {
      RXS_IDLE  = 2'd0,
      RXS_START = 2'd1,
      RXS_BITS  = 2'd2
   } rxs_t;
endpackage

// File: rtl/ser_tick_gen.sv
module ser_tick_gen #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] divisor,
   output logic             tick
);
   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] div_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         div_q <= '0;
         tick  <= 1'b0;
      end else if (divisor != div_q) begin
         div_q <= divisor;
         cnt_q <= '0;
         tick  <= 1'b0;
      end else if (cnt_q == div_q) begin
         cnt_q <= '0;
         tick  <= 1'b1;
      end else begin
         cnt_q <= cnt_q + 1'b1;
         tick  <= 1'b0;
      end
   end

   // R2: with a divisor above zero, two ticks are never adjacent
   p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && div_q != '0 && divisor == div_q) |=> !tick);

   // R8: a divisor change suppresses the tick in the following cycle
   p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (divisor != div_q) |=> !tick);
endmodule

// File: rtl/ser_tx.sv
module ser_tx
   import ser8n1_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OVS    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [DATA_W-1:0] data,
   input  logic              valid,
   output logic              ready,
   output logic              txd
);
   localparam int FRAME_BITS = DATA_W + 2;
   localparam int BIT_W      = $clog2(FRAME_BITS);
   localparam int SUB_W      = (OVS > 2) ? $clog2(OVS) : 1;
   localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);
   localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_BITS - 1);

   txs_t                  state_q;
   logic [FRAME_BITS-1:0] shreg_q;
   logic [BIT_W-1:0]      bit_q;
   logic [SUB_W-1:0]      sub_q;

   assign ready = (state_q == TXS_IDLE);
   assign txd   = (state_q == TXS_SHIFT) ? shreg_q[0] : 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= TXS_IDLE;
         shreg_q <= '1;
         bit_q   <= '0;
         sub_q   <= '0;
      end else begin
         case (state_q)
            TXS_IDLE: begin
               if (valid) begin
                  shreg_q <= {1'b1, data, 1'b0};
                  state_q <= TXS_ARM;
               end
            end
            TXS_ARM: begin
               if (tick) begin
                  state_q <= TXS_SHIFT;
                  sub_q   <= '0;
                  bit_q   <= '0;
               end
            end
            TXS_SHIFT: begin
               if (tick) begin
                  if (sub_q == SUB_LAST) begin
                     sub_q <= '0;
                     if (bit_q == BIT_LAST) begin
                        state_q <= TXS_IDLE;
                     end else begin
                        bit_q   <= bit_q + 1'b1;
                        shreg_q <= {1'b1, shreg_q[FRAME_BITS-1:1]};
                     end
                  end else begin
                     sub_q <= sub_q + 1'b1;
                  end
               end
            end
            default: state_q <= TXS_IDLE;
         endcase
      end
   end

   // R4: an accepted byte drops ready in the next cycle, line still idle
   p_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && ready) |=> (!ready && txd));

   // R3: the line is high whenever the transmitter can accept
   p_idle_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> txd);

   // R2: the line only moves in the cycle after a tick
   p_line_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(txd));
endmodule

// File: rtl/ser_rx.sv
module ser_rx
   import ser8n1_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int OVS         = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              rxd,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_valid,
   output logic              rx_frame_err
);
   localparam int SUB_W  = (OVS > 2) ? $clog2(OVS) : 1;
   localparam int BIT_W  = $clog2(DATA_W + 1);
   localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);
   localparam logic [SUB_W-1:0] SUB_MID  = SUB_W'(OVS / 2 - 1);
   localparam logic [BIT_W-1:0] BIT_STOP = BIT_W'(DATA_W);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   rx_s;
   logic                   prev_q;
   logic                   fall;

   for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) sync_q[0] <= 1'b1;
            else        sync_q[0] <= rxd;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) sync_q[g] <= 1'b1;
            else        sync_q[g] <= sync_q[g-1];
         end
      end
   end

   assign rx_s = sync_q[SYNC_STAGES-1];
   assign fall = prev_q & ~rx_s;

   rxs_t              state_q;
   logic [DATA_W-1:0] shreg_q;
   logic [BIT_W-1:0]  bit_q;
   logic [SUB_W-1:0]  sub_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q       <= 1'b1;
         state_q      <= RXS_IDLE;
         shreg_q      <= '0;
         bit_q        <= '0;
         sub_q        <= '0;
         rx_data      <= '0;
         rx_valid     <= 1'b0;
         rx_frame_err <= 1'b0;
      end else begin
         prev_q   <= rx_s;
         rx_valid <= 1'b0;
         case (state_q)
            RXS_IDLE: begin
               if (fall) begin
                  state_q <= RXS_START;
                  sub_q   <= '0;
               end
            end
            RXS_START: begin
               if (tick) begin
                  if (sub_q == SUB_MID) begin
                     sub_q <= '0;
                     bit_q <= '0;
                     state_q <= rx_s ? RXS_IDLE : RXS_BITS;
                  end else begin
                     sub_q <= sub_q + 1'b1;
                  end
               end
            end
            RXS_BITS: begin
               if (tick) begin
                  if (sub_q == SUB_LAST) begin
                     sub_q <= '0;
                     if (bit_q == BIT_STOP) begin
                        rx_valid     <= 1'b1;
                        rx_data      <= shreg_q;
                        rx_frame_err <= ~rx_s;
                        state_q      <= RXS_IDLE;
                     end else begin
                        shreg_q <= {rx_s, shreg_q[DATA_W-1:1]};
                        bit_q   <= bit_q + 1'b1;
                     end
                  end else begin
                     sub_q <= sub_q + 1'b1;
                  end
               end
            end
            default: state_q <= RXS_IDLE;
         endcase
      end
   end

   // R5: delivery is a single-cycle pulse
   p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   // R7: the start-check phase never delivers a byte
   p_no_deliver_in_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == RXS_START) |=> !rx_valid);

   // R5: a delivery leaves the receiver waiting for a new edge
   p_idle_after_deliver_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> (state_q == RXS_IDLE));
endmodule

// File: rtl/serial_8n1_engine.sv
module serial_8n1_engine #(
   parameter int DIV_W       = 16,
   parameter int DATA_W      = 8,
   parameter int OVS         = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DIV_W-1:0]  divisor,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_valid,
   output logic              tx_ready,
   output logic              txd,
   input  logic              rxd,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_valid,
   output logic              rx_frame_err
);
   if (DIV_W < 1) begin : g_bad_div
      $error("DIV_W must be at least 1");
   end
   if (DATA_W < 5 || DATA_W > 9) begin : g_bad_data
      $error("DATA_W must lie in 5..9");
   end
   if (OVS < 2 || (OVS % 2) != 0) begin : g_bad_ovs
      $error("OVS must be even and at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic tick;

   ser_tick_gen #(.DIV_W(DIV_W)) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .divisor (divisor),
      .tick    (tick)
   );

   ser_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .data  (tx_data),
      .valid (tx_valid),
      .ready (tx_ready),
      .txd   (txd)
   );

   ser_rx #(.DATA_W(DATA_W), .OVS(OVS), .SYNC_STAGES(SYNC_STAGES)) u_rx (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick         (tick),
      .rxd          (rxd),
      .rx_data      (rx_data),
      .rx_valid     (rx_valid),
      .rx_frame_err (rx_frame_err)
   );
endmodule

// File: tb/serial_8n1_engine_test.sv
module serial_8n1_engine_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] divisor = 16'd0;
   logic [7:0]  tx_data = 8'd0;
   logic        tx_valid = 1'b0;
   logic        tx_ready;
   logic        txd;
   logic        rxd = 1'b1;
   logic [7:0]  rx_data;
   logic        rx_valid;
   logic        rx_frame_err;

   int n_tests = 0;
   int n_fail  = 0;
   int cyc     = 0;
   int rx_cnt  = 0;
   logic [7:0] hist_d [0:511];
   logic       hist_e [0:511];
   bit done = 0;

   serial_8n1_engine uut (
      .clk(clk), .rst_n(rst_n), .divisor(divisor),
      .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd),
      .rxd(rxd), .rx_data(rx_data), .rx_valid(rx_valid), .rx_frame_err(rx_frame_err)
   );

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (rst_n && rx_valid) begin
         hist_d[rx_cnt[8:0]] = rx_data;
         hist_e[rx_cnt[8:0]] = rx_frame_err;
         rx_cnt = rx_cnt + 1;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int bit_clocks(input int d);
      return 4 * (d + 1);
   endfunction

   task automatic set_div(input int d);
      @(negedge clk);
      divisor = 16'(d);
      repeat (3) @(negedge clk);
   endtask

   // Transmit one byte and check its waveform on txd
   task automatic tx_send(input logic [7:0] b, input int d);
      int p;
      int t0;
      p = bit_clocks(d);
      @(negedge clk);
      while (!tx_ready) @(negedge clk);
      tx_data  = b;
      tx_valid = 1'b1;
      @(negedge clk);
      tx_valid = 1'b0;
      tx_data  = ~b;                         // R4: must be ignored
      chk("R4 ready low after accept", tx_ready, 0);
      while (txd) @(negedge clk);
      t0 = cyc;
      repeat (p / 2) @(negedge clk);
      chk("R3 start bit", txd, 0);
      for (int i = 0; i < 8; i++) begin
         repeat (p) @(negedge clk);
         chk("R3 data bit lsb first", txd, b[i]);
      end
      repeat (p) @(negedge clk);
      chk("R3 stop bit", txd, 1);
      chk("R4 busy during stop", tx_ready, 0);
      while (!tx_ready) @(negedge clk);
      chk("R2 frame length", cyc - t0, 40 * (d + 1));
   endtask

   task automatic rx_drive(input logic [7:0] b, input logic stop, input int d);
      int p;
      p = bit_clocks(d);
      @(negedge clk);
      rxd = 1'b0;
      repeat (p) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         rxd = b[i];
         repeat (p) @(negedge clk);
      end
      rxd = stop;
      repeat (p) @(negedge clk);
      rxd = 1'b1;
   endtask

   task automatic rx_check(input logic [7:0] b, input logic stop, input int d);
      int c0;
      c0 = rx_cnt;
      rx_drive(b, stop, d);
      repeat (2 * bit_clocks(d) + 8) @(negedge clk);
      chk("R5 one delivery", rx_cnt - c0, 1);
      chk("R5 received byte", hist_d[c0[8:0]], b);
      chk("R6 frame error flag", hist_e[c0[8:0]], !stop);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("  [TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
         $finish;
      end
   end

   initial begin
      int c0;
      int d;
      logic [7:0] b;
      logic st;
      void'($urandom(32'h1a2b3c4d));
      repeat (4) @(negedge clk);
      chk("R1 tx_ready at reset", tx_ready, 1);
      chk("R1 txd at reset", txd, 1);
      chk("R1 rx_valid at reset", rx_valid, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 idle line after reset", txd, 1);

      // Directed transmit patterns, divisor 0 and 2
      set_div(0);
      tx_send(8'hA5, 0);
      tx_send(8'h01, 0);
      set_div(2);
      tx_send(8'h80, 2);
      tx_send(8'hFF, 2);
      tx_send(8'h00, 2);

      // R8: rate change takes effect on the next frame
      set_div(1);
      tx_send(8'h3C, 1);
      set_div(3);
      tx_send(8'hC3, 3);

      // Directed receive, good and bad stop bit
      set_div(0);
      rx_check(8'h5A, 1'b1, 0);
      rx_check(8'h81, 1'b0, 0);
      set_div(3);
      rx_check(8'hF0, 1'b1, 3);
      rx_check(8'h0F, 1'b0, 3);

      // R7: glitch rejection at divisor 3, then a good frame
      c0 = rx_cnt;
      @(negedge clk);
      rxd = 1'b0;
      repeat (2) @(negedge clk);
      rxd = 1'b1;
      repeat (3 * bit_clocks(3)) @(negedge clk);
      chk("R7 glitch rejected", rx_cnt - c0, 0);
      rx_check(8'h96, 1'b1, 3);

      // R9: back-to-back frames with no idle gap
      set_div(1);
      c0 = rx_cnt;
      rx_drive(8'h11, 1'b1, 1);
      rx_drive(8'hEE, 1'b1, 1);
      rx_drive(8'h7B, 1'b1, 1);
      repeat (2 * bit_clocks(1) + 8) @(negedge clk);
      chk("R9 back-to-back count", rx_cnt - c0, 3);
      chk("R9 first byte", hist_d[c0[8:0]], 8'h11);
      chk("R9 second byte", hist_d[(c0 + 1) & 511], 8'hEE);
      chk("R9 third byte", hist_d[(c0 + 2) & 511], 8'h7B);

      // Random mix
      for (int k = 0; k < 24; k++) begin
         d = $urandom_range(0, 3);
         set_div(d);
         b = 8'($urandom);
         tx_send(b, d);
         b = 8'($urandom);
         st = ($urandom_range(0, 3) != 0);
         rx_check(b, st, d);
      end

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule